// File: doc/BRIEF.md
# SMBus Block Transfer Register Slave

This block is a bus slave for a two-wire SMBus segment that holds a small byte-addressed configuration file. A host reaches it at 7-bit address 0x6E. The write form of the address byte is 0xDC and the read form is 0xDD. SCL and SDA are oversampled on the system clock. The block finds START, repeated START and STOP conditions and shifts bytes on SCL edges. It pulls SDA low through an open-drain enable only in acknowledge slots and in the bit slots of bytes it returns.

**Block write.** The host sends START, then 0xDC, then a starting index N, then a byte count X, then the data bytes, then STOP. The data bytes land at N, N+1 and so on, one per byte, and the index advances after each data byte.

**Block read.** The host sends 0xDC and N, then a repeated START, then 0xDD. The slave answers with a count byte and then the data bytes starting at N. The count comes from a writable count register, not from the host. The host acknowledges each byte it wants and ends the read with a NACK.

**Local interface.** Other logic sees the file through a combinational read port. It is told of every committed bus write by a one-cycle update strobe.

**Register file defaults.** There are eight bytes. Index 4 is a read-only vendor/revision byte with value 0x01. Index 5 is a read-only device byte with value 0x07. Index 6 is the read-count register, which resets to 0x07. Every other byte resets to 0x00.

Top module: `smb_blk_regs`

## Requirements
- R1: The slave acknowledges the address bytes 0xDC and 0xDD. Any other address byte is not acknowledged, and the bytes that follow it are neither acknowledged nor acted on until the next START.
- R2: In a block write, the slave acknowledges the address, the index byte N, the count byte X and each of the X data bytes. Data byte k (k counted from 0) is stored at index N+k.
- R3: A data byte that arrives after X data bytes have been taken is not acknowledged and is not stored.
- R4: A data byte aimed at index 4 or index 5 is acknowledged but leaves the stored value unchanged. The index still advances past it.
- R5: After 0xDC, N, a repeated START and 0xDD, the slave sends the value of byte 6 as the count byte. It then sends the bytes at N, N+1 and so on, most significant bit first.
- R6: Byte 6 resets to 0x07, and writing it sets how many data bytes a block read returns. Once that many data bytes have been sent, the slave leaves SDA released, so further bytes read as 0xFF.
- R7: After reset, byte 4 reads 0x01, byte 5 reads 0x07, byte 6 reads 0x07, and bytes 0 to 3 and 7 read 0x00. SDA is released.
- R8: A NACK from the host on a read byte makes the slave release SDA. The slave then stays idle until the next START.
- R9: A START seen in the middle of a byte restarts address reception. A STOP seen in the middle of a byte returns the slave to idle. In both cases the partly received byte is not stored, and a stored index survives the repeated START.
- R10: The slave begins pulling SDA low only while SCL is low. When idle it never pulls SDA low.
- R11: loc_rdata shows the byte at loc_idx in the same cycle. Every stored bus write raises upd_vld for one cycle, with the written index on upd_idx and the written value on upd_data.
- R12: Indices 8 and above hold nothing. Writes to them are acknowledged but store nothing and raise no update strobe, and reads from them return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Level of the SCL line |
| sda_i | input | 1 | Level of the SDA line |
| sda_oe | output | 1 | When 1, the pad pulls SDA low |
| loc_idx | input | 8 | Index for the local read port |
| loc_rdata | output | 8 | Byte stored at loc_idx |
| upd_vld | output | 1 | One-cycle strobe for a stored bus write |
| upd_idx | output | 8 | Index of the stored bus write |
| upd_data | output | 8 | Value of the stored bus write |

## Verification
The assertions assume the following about the bus:
- SCL stays at each level for several system clocks, longer than the three-stage sampling path, so every SCL edge is seen once and in order.
- Only START and STOP conditions move SDA while SCL is high.

The bench keeps within these assumptions. Its master waits six system clocks per quarter bit and changes SDA only while SCL is low, except when it forms a START or STOP. It aborts a transfer only during bytes that the host is sending, and never while the slave may be holding SDA low.

// File: rtl/smb_blk_regs.sv
module smb_blk_regs #(
  parameter logic [6:0] DEV_ADDR  = 7'h6E,
  parameter int         REG_COUNT = 8,
  parameter int         CNT_IDX   = 6,
  parameter int         VID_IDX   = 4,
  parameter int         DID_IDX   = 5,
  parameter logic [7:0] VENDOR_ID = 8'h01,
  parameter logic [7:0] DEVICE_ID = 8'h07,
  parameter logic [7:0] DEF_COUNT = 8'h07
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe,
  input  logic [7:0] loc_idx,
  output logic [7:0] loc_rdata,
  output logic       upd_vld,
  output logic [7:0] upd_idx,
  output logic [7:0] upd_data
);
  localparam int         IW    = (REG_COUNT > 1) ? $clog2(REG_COUNT) : 1;
  localparam logic [8:0] RC9   = 9'(REG_COUNT);
  localparam logic [7:0] VID_B = 8'(VID_IDX);
  localparam logic [7:0] DID_B = 8'(DID_IDX);

  typedef enum logic [2:0] {ST_IDLE, ST_ADDR, ST_CMD, ST_CNT, ST_WDAT, ST_RDAT} st_t;

  st_t        state;
  logic [2:0] scl_p, sda_p;
  logic [3:0] cnt;
  logic [7:0] sr, txb, idx, wcnt, rcnt;
  logic       rd_req, mack;
  logic [7:0] rf [REG_COUNT];

  wire scl_s     = scl_p[1];
  wire sda_s     = sda_p[1];
  wire scl_rise  = scl_p[1] & ~scl_p[2];
  wire scl_fall  = ~scl_p[1] & scl_p[2];
  wire start_det = scl_p[1] & scl_p[2] & ~sda_p[1] & sda_p[2];
  wire stop_det  = scl_p[1] & scl_p[2] & sda_p[1] & ~sda_p[2];

  function automatic logic [7:0] rd_mux(input logic [7:0] a);
    if ({1'b0, a} >= RC9) return 8'h00;
    if (a == VID_B) return VENDOR_ID;
    if (a == DID_B) return DEVICE_ID;
    return rf[a[IW-1:0]];
  endfunction

  function automatic logic writable(input logic [7:0] a);
    return ({1'b0, a} < RC9) && (a != VID_B) && (a != DID_B);
  endfunction

  wire [7:0] cnt_reg = rf[CNT_IDX];
  wire [7:0] fetch   = (rcnt != 8'h00) ? rd_mux(idx) : 8'hFF;
  assign loc_rdata   = rd_mux(loc_idx);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_p <= 3'b111;
      sda_p <= 3'b111;
    end else begin
      scl_p <= {scl_p[1:0], scl_i};
      sda_p <= {sda_p[1:0], sda_i};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      cnt      <= '0;
      sr       <= '0;
      txb      <= 8'hFF;
      idx      <= '0;
      wcnt     <= '0;
      rcnt     <= '0;
      rd_req   <= 1'b0;
      mack     <= 1'b0;
      sda_oe   <= 1'b0;
      upd_vld  <= 1'b0;
      upd_idx  <= '0;
      upd_data <= '0;
      for (int i = 0; i < REG_COUNT; i++) rf[i] <= (i == CNT_IDX) ? DEF_COUNT : 8'h00;
    end else begin
      upd_vld <= 1'b0;
      if (start_det) begin
        state  <= ST_ADDR;
        cnt    <= '0;
        sda_oe <= 1'b0;
      end else if (stop_det) begin
        state  <= ST_IDLE;
        cnt    <= '0;
        sda_oe <= 1'b0;
      end else if (state != ST_IDLE) begin
        if (scl_rise) begin
          if (cnt < 4'd8) sr <= {sr[6:0], sda_s};
          else            mack <= ~sda_s;
          cnt <= cnt + 4'd1;
        end else if (scl_fall) begin
          if (cnt < 4'd8) begin
            sda_oe <= (state == ST_RDAT) ? ~txb[~cnt[2:0]] : 1'b0;
          end else if (cnt == 4'd8) begin
            case (state)
              ST_ADDR: begin
                if (sr[7:1] == DEV_ADDR) begin
                  sda_oe <= 1'b1;
                  rd_req <= sr[0];
                end else begin
                  sda_oe <= 1'b0;
                  state  <= ST_IDLE;
                end
              end
              ST_CMD: begin
                idx    <= sr;
                sda_oe <= 1'b1;
              end
              ST_CNT: begin
                wcnt   <= sr;
                sda_oe <= 1'b1;
              end
              ST_WDAT: begin
                if (wcnt != 8'h00) begin
                  sda_oe <= 1'b1;
                  wcnt   <= wcnt - 8'd1;
                  idx    <= idx + 8'd1;
                  if (writable(idx)) begin
                    rf[idx[IW-1:0]] <= sr;
                    upd_vld  <= 1'b1;
                    upd_idx  <= idx;
                    upd_data <= sr;
                  end
                end else begin
                  sda_oe <= 1'b0;
                  state  <= ST_IDLE;
                end
              end
              default: sda_oe <= 1'b0;
            endcase
          end else begin
            cnt    <= '0;
            sda_oe <= 1'b0;
            case (state)
              ST_ADDR: begin
                if (rd_req) begin
                  state  <= ST_RDAT;
                  txb    <= cnt_reg;
                  rcnt   <= cnt_reg;
                  sda_oe <= ~cnt_reg[7];
                end else begin
                  state <= ST_CMD;
                end
              end
              ST_CMD: state <= ST_CNT;
              ST_CNT: state <= ST_WDAT;
              ST_RDAT: begin
                if (mack) begin
                  txb    <= fetch;
                  sda_oe <= ~fetch[7];
                  if (rcnt != 8'h00) begin
                    rcnt <= rcnt - 8'd1;
                    idx  <= idx + 8'd1;
                  end
                end else begin
                  state <= ST_IDLE;
                end
              end
              default: ;
            endcase
          end
        end
      end
    end
  end

  // R10
  drive_on_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !$past(scl_s));

  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE) |-> !sda_oe);

  // R9
  stop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det && !start_det |=> (state == ST_IDLE));

  // R9
  start_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> (state == ST_ADDR) && (cnt == 4'd0));

  // R4 R12
  ro_untouched_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd_vld |-> (upd_idx != VID_B) && (upd_idx != DID_B) && ({1'b0, upd_idx} < RC9));

  // R11
  upd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd_vld |=> !upd_vld);

  // R2
  frame_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= 4'd9);
endmodule

// File: tb/smb_blk_regs_bench.sv
module smb_blk_regs_bench;
  localparam int Q = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1;
  logic m_sda = 1'b1;
  logic [7:0] loc_idx = 8'h00;
  logic sda_oe, upd_vld;
  logic [7:0] loc_rdata, upd_idx, upd_data;
  wire sda_line = m_sda & ~sda_oe;

  int checks = 0;
  int errs = 0;
  int upd_n = 0;
  int bad_drv = 0;
  logic [7:0] last_idx, last_data;
  logic prev_oe = 1'b0;

  always #5 clk = ~clk;

  smb_blk_regs u_smb_blk_regs (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line), .sda_oe(sda_oe),
    .loc_idx(loc_idx), .loc_rdata(loc_rdata),
    .upd_vld(upd_vld), .upd_idx(upd_idx), .upd_data(upd_data)
  );

  always @(posedge clk) begin
    prev_oe <= sda_oe;
    if (sda_oe && !prev_oe && m_scl) bad_drv++;
    if (upd_vld) begin
      upd_n++;
      last_idx  <= upd_idx;
      last_data <= upd_data;
    end
  end

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic hq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic start_c();
    m_sda = 1'b1; hq(); m_scl = 1'b1; hq(); m_sda = 1'b0; hq(); m_scl = 1'b0; hq();
  endtask

  task automatic stop_c();
    m_sda = 1'b0; hq(); m_scl = 1'b1; hq(); m_sda = 1'b1; hq(); hq();
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 0; i < n; i++) begin
      m_sda = b[7-i]; hq(); m_scl = 1'b1; hq(); hq(); m_scl = 1'b0; hq();
    end
  endtask

  task automatic wr_chk(input logic [7:0] b, input logic exp_ack, input string tag);
    logic ack;
    send_bits(b, 8);
    m_sda = 1'b1; hq(); m_scl = 1'b1; hq();
    ack = ~sda_line;
    hq(); m_scl = 1'b0; hq();
    chk({tag, " ack"}, {7'd0, ack}, {7'd0, exp_ack});
  endtask

  task automatic rd_chk(input logic ack_in, input logic [7:0] exp, input string tag);
    logic [7:0] b = 8'h00;
    m_sda = 1'b1;
    for (int i = 0; i < 8; i++) begin
      hq(); m_scl = 1'b1; hq(); b = {b[6:0], sda_line}; hq(); m_scl = 1'b0; hq();
    end
    m_sda = ack_in ? 1'b0 : 1'b1;
    hq(); m_scl = 1'b1; hq(); hq(); m_scl = 1'b0; hq();
    m_sda = 1'b1;
    chk({tag, " read"}, b, exp);
  endtask

  task automatic loc_chk(input logic [7:0] i, input logic [7:0] exp, input string tag);
    loc_idx = i;
    @(negedge clk);
    chk(tag, loc_rdata, exp);
  endtask

  task automatic t_reset();
    for (int i = 0; i < 8; i++)
      loc_chk(8'(i), (i == 4) ? 8'h01 : (i == 5 || i == 6) ? 8'h07 : 8'h00, "R7 reset byte");
    chk("R7 sda released", {7'd0, sda_oe}, 8'h00);
  endtask

  task automatic t_write();
    int n0 = upd_n;
    start_c();
    wr_chk(8'hDC, 1'b1, "R1 write addr");
    wr_chk(8'h00, 1'b1, "R2 index");
    wr_chk(8'h03, 1'b1, "R2 count");
    wr_chk(8'hA1, 1'b1, "R2 data0");
    wr_chk(8'hB2, 1'b1, "R2 data1");
    wr_chk(8'hC3, 1'b1, "R2 data2");
    stop_c();
    loc_chk(8'd0, 8'hA1, "R2 byte0");
    loc_chk(8'd1, 8'hB2, "R2 byte1");
    loc_chk(8'd2, 8'hC3, "R2 byte2");
    chk("R11 strobe count", 8'(upd_n - n0), 8'd3);
    chk("R11 last idx", last_idx, 8'd2);
    chk("R11 last data", last_data, 8'hC3);
  endtask

  task automatic t_over();
    start_c();
    wr_chk(8'hDC, 1'b1, "R3 addr");
    wr_chk(8'h02, 1'b1, "R3 index");
    wr_chk(8'h01, 1'b1, "R3 count");
    wr_chk(8'h11, 1'b1, "R3 data0");
    wr_chk(8'h22, 1'b0, "R3 extra nack");
    stop_c();
    loc_chk(8'd2, 8'h11, "R3 byte2");
    loc_chk(8'd3, 8'h00, "R3 byte3 untouched");
  endtask

  task automatic t_ro();
    int n0 = upd_n;
    start_c();
    wr_chk(8'hDC, 1'b1, "R4 addr");
    wr_chk(8'h03, 1'b1, "R4 index");
    wr_chk(8'h03, 1'b1, "R4 count");
    wr_chk(8'h33, 1'b1, "R4 data3");
    wr_chk(8'h44, 1'b1, "R4 data4 ack");
    wr_chk(8'h55, 1'b1, "R4 data5 ack");
    stop_c();
    loc_chk(8'd3, 8'h33, "R4 byte3");
    loc_chk(8'd4, 8'h01, "R4 byte4 kept");
    loc_chk(8'd5, 8'h07, "R4 byte5 kept");
    chk("R4 strobe count", 8'(upd_n - n0), 8'd1);
    start_c();
    wr_chk(8'hDC, 1'b1, "R4 addr");
    wr_chk(8'h05, 1'b1, "R4 index");
    wr_chk(8'h02, 1'b1, "R4 count");
    wr_chk(8'hEE, 1'b1, "R4 ro data");
    wr_chk(8'h02, 1'b1, "R6 count data");
    stop_c();
    loc_chk(8'd5, 8'h07, "R4 byte5 kept");
    loc_chk(8'd6, 8'h02, "R4 index advanced");
  endtask

  task automatic t_read();
    start_c();
    wr_chk(8'hDC, 1'b1, "R5 addr");
    wr_chk(8'h00, 1'b1, "R5 index");
    start_c();
    wr_chk(8'hDD, 1'b1, "R1 read addr");
    rd_chk(1'b1, 8'h02, "R6 count byte");
    rd_chk(1'b1, 8'hA1, "R5 data0");
    rd_chk(1'b1, 8'hB2, "R5 data1");
    rd_chk(1'b0, 8'hFF, "R6 past count");
    stop_c();
  endtask

  task automatic t_read_full();
    logic [7:0] exp [7] = '{8'hB2, 8'h11, 8'h33, 8'h01, 8'h07, 8'h07, 8'h00};
    start_c();
    wr_chk(8'hDC, 1'b1, "R6 addr");
    wr_chk(8'h06, 1'b1, "R6 index");
    wr_chk(8'h01, 1'b1, "R6 count");
    wr_chk(8'h07, 1'b1, "R6 new count");
    stop_c();
    loc_chk(8'd6, 8'h07, "R6 count reg");
    start_c();
    wr_chk(8'hDC, 1'b1, "R5 addr");
    wr_chk(8'h01, 1'b1, "R5 index");
    start_c();
    wr_chk(8'hDD, 1'b1, "R5 read addr");
    rd_chk(1'b1, 8'h07, "R5 count byte");
    for (int i = 0; i < 7; i++) rd_chk(i != 6, exp[i], "R5 data");
    stop_c();
  endtask

  task automatic t_nack();
    start_c();
    wr_chk(8'hDC, 1'b1, "R8 addr");
    wr_chk(8'h00, 1'b1, "R8 index");
    start_c();
    wr_chk(8'hDD, 1'b1, "R8 read addr");
    rd_chk(1'b1, 8'h07, "R8 count byte");
    rd_chk(1'b0, 8'hA1, "R8 data0");
    rd_chk(1'b1, 8'hFF, "R8 after nack");
    stop_c();
  endtask

  task automatic t_badaddr();
    start_c();
    wr_chk(8'hA0, 1'b0, "R1 foreign addr");
    wr_chk(8'h00, 1'b0, "R1 ignored index");
    wr_chk(8'h01, 1'b0, "R1 ignored count");
    wr_chk(8'h55, 1'b0, "R1 ignored data");
    stop_c();
    loc_chk(8'd0, 8'hA1, "R1 byte0 kept");
  endtask

  task automatic t_abort();
    int n0 = upd_n;
    start_c();
    wr_chk(8'hDC, 1'b1, "R9 addr");
    wr_chk(8'h00, 1'b1, "R9 index");
    wr_chk(8'h02, 1'b1, "R9 count");
    send_bits(8'h5A, 4);
    stop_c();
    loc_chk(8'd0, 8'hA1, "R9 stop abort");
    chk("R9 no strobe", 8'(upd_n - n0), 8'd0);
    start_c();
    wr_chk(8'hDC, 1'b1, "R9 addr");
    wr_chk(8'h00, 1'b1, "R9 index");
    wr_chk(8'h01, 1'b1, "R9 count");
    send_bits(8'h0F, 5);
    start_c();
    wr_chk(8'hDC, 1'b1, "R9 restart addr");
    wr_chk(8'h07, 1'b1, "R9 index");
    wr_chk(8'h01, 1'b1, "R9 count");
    wr_chk(8'h3C, 1'b1, "R9 data");
    stop_c();
    loc_chk(8'd0, 8'hA1, "R9 start abort");
    loc_chk(8'd7, 8'h3C, "R9 after restart");
  endtask

  task automatic t_range();
    int n0 = upd_n;
    start_c();
    wr_chk(8'hDC, 1'b1, "R12 addr");
    wr_chk(8'h09, 1'b1, "R12 index");
    wr_chk(8'h01, 1'b1, "R12 count");
    wr_chk(8'h12, 1'b1, "R12 data");
    stop_c();
    chk("R12 no strobe", 8'(upd_n - n0), 8'd0);
    loc_chk(8'd9, 8'h00, "R12 local read");
    start_c();
    wr_chk(8'hDC, 1'b1, "R12 addr");
    wr_chk(8'h20, 1'b1, "R12 index");
    start_c();
    wr_chk(8'hDD, 1'b1, "R12 read addr");
    rd_chk(1'b1, 8'h07, "R12 count byte");
    rd_chk(1'b0, 8'h00, "R12 empty data");
    stop_c();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errs++;
    checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_write();
    t_over();
    t_ro();
    t_read();
    t_read_full();
    t_nack();
    t_badaddr();
    t_abort();
    t_range();
    chk("R10 drive while SCL high", 8'(bad_drv), 8'd0);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule